// File: doc/BRIEF.md
# Tristate Phase-Frequency Detector with Power Control

This block compares a divided reference pulse train (`refIn`) with a divided feedback pulse train (`fbIn`) and produces the two switch commands of a charge pump. The output has three states: source (`pumpUp`), sink (`pumpDown`) and high impedance (`hiZ`). Two edge-set state flops record which input rose first. Once both are set, they stay set for a fixed number of clocks and then clear together. Because of this overlap, even a zero phase error produces a pulse of known minimum width on both outputs, so the detector has no dead zone. A programmed polarity bit exchanges the roles of the two outputs, so the block can drive a VCO whose frequency rises or falls with control voltage.

Power control has two sources, and either one puts the block in power-down:
- a programmed power-down bit, which acts synchronously;
- a chip-enable pin, which acts asynchronously and overrides the bit.

In power-down, the detector state is cleared, the outputs are released to high impedance, and input edges are ignored. The block also drives a divider-reset line, which holds the external reference and feedback dividers in reset. All inputs are sampled in the `clk` domain, and edges are detected as a 0-to-1 change between samples.

Top module: `pfd_tristate`

## Requirements
- R1: While `rstN` is low, `pumpUp` and `pumpDown` are 0, `hiZ` is 1 and `divReset` is 1.
- R2: With `polInvert`=0, if `refIn` rises d clock cycles (d>=1) before `fbIn`, `pumpUp` is high for d+RESET_DELAY cycles and `pumpDown` for RESET_DELAY cycles.
- R3: With `polInvert`=0, if `fbIn` rises d cycles (d>=1) before `refIn`, `pumpDown` is high for d+RESET_DELAY cycles and `pumpUp` for RESET_DELAY cycles.
- R4: When both inputs rise on the same cycle, each output produces a pulse of exactly RESET_DELAY cycles, and no pulse is ever shorter than RESET_DELAY cycles unless power-down cuts it.
- R5: With `polInvert`=1, the roles of `pumpUp` and `pumpDown` in R2 to R4 are swapped.
- R6: `hiZ` is 1 exactly when neither `pumpUp` nor `pumpDown` is active.
- R7: With `chipEn`=1, setting `pwrDownBit` to 1 forces both pump outputs to 0 and `hiZ` to 1 at once. It also clears any pending detector state, and edges that arrive during power-down are ignored, so no pulse appears after release.
- R8: `chipEn`=0 forces both pump outputs to 0, `hiZ` to 1 and `divReset` to 1 without waiting for a clock edge, whatever the value of `pwrDownBit`.
- R9: `divReset` is 1 throughout power-down and for one further clock edge after power-down ends, then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEn | input | 1 | Chip enable; low means asynchronous power-down |
| pwrDownBit | input | 1 | Programmed power-down bit |
| polInvert | input | 1 | 1 swaps the up and down commands |
| refIn | input | 1 | Divided reference pulse train |
| fbIn | input | 1 | Divided feedback pulse train |
| pumpUp | output | 1 | Charge-pump source command |
| pumpDown | output | 1 | Charge-pump sink command |
| hiZ | output | 1 | Charge-pump output in high impedance |
| divReset | output | 1 | Holds the reference and feedback dividers in reset |

## Verification
The timing of each result, measured from a stimulus, is as follows:
- An input rise is registered at the next clock edge, so the matching pump output changes one edge after the rise is driven.
- The clearing of both flops lands RESET_DELAY edges after the second of them was set.
- The power-down bit and chip enable act on the outputs combinationally, with no clock edge needed.
- `divReset` drops one edge after power-down ends.

The bench drives inputs on the falling clock edge and samples one falling edge later, where one clock edge is involved. Pulse widths are found by counting high samples over a window that covers the whole pulse. The asynchronous and combinational results are sampled 1 ns after the input change, before any rising edge has occurred.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

  // Strobes from control to datapath, evaluated for the next clock edge.
  typedef struct packed {
    logic setUp;    // reference rise registered
    logic setDn;    // feedback rise registered
    logic clrBoth;  // overlap delay elapsed, clear both flops
    logic hold;     // power-down: keep both flops cleared
  } pfdStrobes_t;

endpackage

// File: rtl/pfd_ctrl.sv
`timescale 1ns/1ps
module pfd_ctrl
  import pfd_pkg::*;
#(
  parameter int RESET_DELAY = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clrN,
  input  logic        chipEn,
  input  logic        pwrDownBit,
  input  logic        refIn,
  input  logic        fbIn,
  input  logic        upState,
  input  logic        dnState,
  output pfdStrobes_t strobes,
  output logic        powerDown,
  output logic        divReset
);

  localparam int CNT_W = (RESET_DELAY > 1) ? $clog2(RESET_DELAY) : 1;

  logic refPrev;
  logic fbPrev;
  logic pdPrev;
  logic bothSet;
  logic refRise;
  logic fbRise;
  logic delayDone;

  assign powerDown = ~chipEn | pwrDownBit;
  assign bothSet   = upState & dnState;

  // Edge history follows the inputs even in power-down, so a level that is
  // already high at release is not mistaken for a fresh edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b1;
      fbPrev  <= 1'b1;
      pdPrev  <= 1'b1;
    end else begin
      refPrev <= refIn;
      fbPrev  <= fbIn;
      pdPrev  <= powerDown;
    end
  end

  assign refRise = refIn & ~refPrev & ~powerDown;
  assign fbRise  = fbIn  & ~fbPrev  & ~powerDown;

  generate
    if (RESET_DELAY <= 1) begin : gen_noCount
      assign delayDone = bothSet;
    end else begin : gen_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(RESET_DELAY - 1);
      logic [CNT_W-1:0] overlapCnt;

      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN) begin
          overlapCnt <= '0;
        end else if (powerDown || !bothSet || overlapCnt == LAST) begin
          overlapCnt <= '0;
        end else begin
          overlapCnt <= overlapCnt + 1'b1;
        end
      end

      assign delayDone = bothSet & (overlapCnt == LAST);
    end
  endgenerate

  always_comb begin
    strobes.hold    = powerDown;
    strobes.clrBoth = delayDone;
    strobes.setUp   = refRise & ~bothSet;
    strobes.setDn   = fbRise & ~bothSet;
  end

  // Held through power-down and one edge past it; chip enable reaches it
  // without a clock.
  assign divReset = powerDown | pdPrev;

endmodule

// File: rtl/pfd_datapath.sv
`timescale 1ns/1ps
module pfd_datapath
  import pfd_pkg::*;
(
  input  logic        clk,
  input  logic        clrN,
  input  pfdStrobes_t strobes,
  input  logic        powerDown,
  input  logic        polInvert,
  output logic        upState,
  output logic        dnState,
  output logic        pumpUp,
  output logic        pumpDown,
  output logic        hiZ
);

  logic srcCmd;
  logic snkCmd;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      upState <= 1'b0;
      dnState <= 1'b0;
    end else if (strobes.hold || strobes.clrBoth) begin
      upState <= 1'b0;
      dnState <= 1'b0;
    end else begin
      if (strobes.setUp) upState <= 1'b1;
      if (strobes.setDn) dnState <= 1'b1;
    end
  end

  always_comb begin
    srcCmd   = polInvert ? dnState : upState;
    snkCmd   = polInvert ? upState : dnState;
    pumpUp   = srcCmd & ~powerDown;
    pumpDown = snkCmd & ~powerDown;
    hiZ      = powerDown | ~(srcCmd | snkCmd);
  end

endmodule

// File: rtl/pfd_tristate.sv
`timescale 1ns/1ps
module pfd_tristate
  import pfd_pkg::*;
#(
  parameter int RESET_DELAY = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipEn,
  input  logic pwrDownBit,
  input  logic polInvert,
  input  logic refIn,
  input  logic fbIn,
  output logic pumpUp,
  output logic pumpDown,
  output logic hiZ,
  output logic divReset
);

  pfdStrobes_t strobes;
  logic        powerDown;
  logic        upState;
  logic        dnState;
  logic        clrN;

  // Chip enable joins the detector's asynchronous clear.
  assign clrN = rstN & chipEn;

  pfd_ctrl #(
    .RESET_DELAY(RESET_DELAY)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clrN      (clrN),
    .chipEn    (chipEn),
    .pwrDownBit(pwrDownBit),
    .refIn     (refIn),
    .fbIn      (fbIn),
    .upState   (upState),
    .dnState   (dnState),
    .strobes   (strobes),
    .powerDown (powerDown),
    .divReset  (divReset)
  );

  pfd_datapath u_datapath (
    .clk      (clk),
    .clrN     (clrN),
    .strobes  (strobes),
    .powerDown(powerDown),
    .polInvert(polInvert),
    .upState  (upState),
    .dnState  (dnState),
    .pumpUp   (pumpUp),
    .pumpDown (pumpDown),
    .hiZ      (hiZ)
  );

endmodule

// File: rtl/pfd_tristate_checker.sv
`timescale 1ns/1ps
module pfd_tristate_checker #(
  parameter int RESET_DELAY = 3
) (
  input logic clk,
  input logic rstN,
  input logic chipEn,
  input logic pwrDownBit,
  input logic polInvert,
  input logic pumpUp,
  input logic pumpDown,
  input logic hiZ,
  input logic divReset
);

  logic [7:0] upRun;
  logic [7:0] dnRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upRun <= '0;
      dnRun <= '0;
    end else begin
      upRun <= pumpUp   ? ((upRun == 8'hFF) ? upRun : upRun + 8'd1) : 8'd0;
      dnRun <= pumpDown ? ((dnRun == 8'hFF) ? dnRun : dnRun + 8'd1) : 8'd0;
    end
  end

  assert_min_width_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pumpUp) && chipEn && !pwrDownBit && $past(chipEn) && !$past(pwrDownBit)
      && $stable(polInvert)) |-> (int'(upRun) >= RESET_DELAY));

  assert_min_width_dn_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pumpDown) && chipEn && !pwrDownBit && $past(chipEn) && !$past(pwrDownBit)
      && $stable(polInvert)) |-> (int'(dnRun) >= RESET_DELAY));

  assert_active_not_hiz_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pumpUp || pumpDown) |-> !hiZ);

  assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    pwrDownBit |-> (!pumpUp && !pumpDown && hiZ && divReset));

  assert_ce_override_R8: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |-> (!pumpUp && !pumpDown && hiZ && divReset));

  assert_div_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(divReset) |-> (chipEn && !pwrDownBit && $past(chipEn) && !$past(pwrDownBit)));

endmodule

bind pfd_tristate pfd_tristate_checker #(
  .RESET_DELAY(RESET_DELAY)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .chipEn    (chipEn),
  .pwrDownBit(pwrDownBit),
  .polInvert (polInvert),
  .pumpUp    (pumpUp),
  .pumpDown  (pumpDown),
  .hiZ       (hiZ),
  .divReset  (divReset)
);

// File: tb/pfd_tristate_bench.sv
`timescale 1ns/1ps
module pfd_tristate_bench;

  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEn = 1'b1;
  logic pwrDownBit = 1'b0;
  logic polInvert = 1'b0;
  logic refIn = 1'b0;
  logic fbIn = 1'b0;
  logic pumpUp, pumpDown, hiZ, divReset;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pfd_tristate #(.RESET_DELAY(DLY)) u_pfd_tristate (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .pwrDownBit(pwrDownBit),
    .polInvert(polInvert), .refIn(refIn), .fbIn(fbIn),
    .pumpUp(pumpUp), .pumpDown(pumpDown), .hiZ(hiZ), .divReset(divReset)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Applies one reference/feedback pair with offset d (d>0: reference leads).
  task automatic runPair(input int d, input bit pol);
    int tRef, tFb, upCnt, dnCnt, hizBad, expUp, expDn;
    string reqTag;
    polInvert = pol;
    tRef = (d < 0) ? -d : 0;
    tFb  = (d > 0) ? d : 0;
    upCnt = 0; dnCnt = 0; hizBad = 0;
    for (int t = 0; t < 40; t++) begin
      tick();
      if (pumpUp) upCnt++;
      if (pumpDown) dnCnt++;
      if (hiZ != !(pumpUp || pumpDown)) hizBad++;
      refIn = (t >= tRef);
      fbIn  = (t >= tFb);
    end
    refIn = 1'b0; fbIn = 1'b0;
    repeat (4) tick();
    // Leading side gets the offset plus the overlap; the other gets the overlap.
    expUp = (d > 0) ? d + DLY : DLY;
    expDn = (d < 0) ? -d + DLY : DLY;
    if (pol) begin
      int tmp = expUp; expUp = expDn; expDn = tmp;
    end
    if (pol) reqTag = "R5";
    else if (d > 0) reqTag = "R2";
    else if (d < 0) reqTag = "R3";
    else reqTag = "R4";
    check(reqTag, $sformatf("pumpUp width d=%0d pol=%0d", d, pol), upCnt, expUp);
    check(reqTag, $sformatf("pumpDown width d=%0d pol=%0d", d, pol), dnCnt, expDn);
    check("R6", $sformatf("hiZ mismatches d=%0d pol=%0d", d, pol), hizBad, 0);
  endtask

  initial begin
    #150000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    check("R1", "pumpUp in reset", pumpUp, 0);
    check("R1", "pumpDown in reset", pumpDown, 0);
    check("R1", "hiZ in reset", hiZ, 1);
    check("R1", "divReset in reset", divReset, 1);
    rstN = 1'b1;
    repeat (3) tick();
    check("R9", "divReset after reset release", divReset, 0);

    // R2 R3 R4 R5 R6: offset sweep under both polarities
    for (int p = 0; p < 2; p++) begin
      for (int d = -6; d <= 6; d++) begin
        runPair(d, p[0]);
      end
    end
    polInvert = 1'b0;

    // R7: programmed power-down cuts a pending pulse and ignores edges
    refIn = 1'b1;
    tick();
    check("R2", "pumpUp before power-down", pumpUp, 1);
    pwrDownBit = 1'b1;
    #1;
    check("R7", "pumpUp forced off", pumpUp, 0);
    check("R7", "hiZ forced", hiZ, 1);
    check("R9", "divReset during power-down", divReset, 1);
    tick();
    refIn = 1'b0;
    tick();
    refIn = 1'b1;
    fbIn = 1'b1;
    tick();
    refIn = 1'b0;
    tick();
    pwrDownBit = 1'b0;
    #1;
    check("R9", "divReset one edge after release", divReset, 1);
    tick();
    check("R9", "divReset drops", divReset, 0);
    check("R7", "no pumpUp after release", pumpUp, 0);
    check("R7", "no pumpDown after release", pumpDown, 0);
    repeat (5) tick();
    check("R7", "still idle pumpDown", pumpDown, 0);
    check("R7", "still idle hiZ", hiZ, 1);
    fbIn = 1'b0;
    repeat (3) tick();

    // R8: chip enable low between clock edges overrides a clear bit
    refIn = 1'b1;
    tick();
    check("R2", "pumpUp before chip disable", pumpUp, 1);
    #1;
    chipEn = 1'b0;
    #0.5;
    check("R8", "pumpUp off without clock", pumpUp, 0);
    check("R8", "hiZ without clock", hiZ, 1);
    check("R8", "divReset without clock", divReset, 1);
    repeat (3) tick();
    check("R8", "hiZ held with bit clear", hiZ, 1);
    chipEn = 1'b1;
    #1;
    check("R9", "divReset extra edge after enable", divReset, 1);
    tick();
    check("R8", "detector cleared pumpUp", pumpUp, 0);
    check("R9", "divReset low after enable", divReset, 0);
    refIn = 1'b0;
    repeat (3) tick();

    // R5 R2 regression after power cycle: detector works again
    runPair(2, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule